// File: doc/BRIEF.md
# Multi-Compare Pulse Pattern Timer

This block is a 16-bit up-counter that produces a programmable pulse train on one output pin. One, two or three compare values are in use at a time. A 2-bit count field in the control word selects how many. The counter advances only on cycles where an external prescaler tick is high. When the count equals an active compare value that is not the last one in use, the pulse output inverts. When the count equals the last active value, that value sets the period. The counter then returns to zero, the output returns to its programmed starting level, and a one-clock interrupt pulse is raised.

Counting is started by a software command or by an edge on a trigger pin. The trigger edge can be rising, falling or both, and a disable bit turns it off. A qualifying trigger edge while the timer is running restarts the period. A stop command freezes both the count and the output level.

Compare values and the count field are written into shadow copies at any time. The active set is reloaded from the shadows only when a period ends or counting starts, so software can change the pattern within one period and have it take effect cleanly from the next. Writes to the second and third compare slots are refused unless pulse mode is on and the count field currently held includes that slot.

Top module: `ppg_timer`

## Requirements
- R1: After reset `pulse_out` and `irq` are 0 and the counter is stopped, so no interrupt appears until counting is started.
- R2: While running, the counter and `pulse_out` change only on clock edges where `tick` is 1. With `tick` at 0 both hold.
- R3: On a tick edge where the count equals an active compare value that is not the last active one, `pulse_out` inverts at that edge. An odd number of such equal values inverts it and an even number leaves it.
- R4: The count field is control bits [2:1]. Values 0 and 1 use slot A only, 2 uses A and B, and 3 uses A, B and C. On a tick edge where the count equals the last active value V, the count becomes 0, `pulse_out` takes the initial level, and `irq` is 1 for exactly the next cycle, so one period lasts V+1 ticks.
- R5: Writing address 1 with bit 0 set starts counting. It clears the count to 0, loads `pulse_out` with the initial level (control bit 3) and loads the active compare set from the shadows. Compare slots A, B and C are addresses 2, 3 and 4, and the control word is address 0.
- R6: Writing address 1 with bit 1 set and bit 0 clear stops counting. While stopped, `pulse_out` holds its level and `irq` stays 0 until the next start.
- R7: Control bits [5:4] select the trigger edge on `trig_in`: 0 is off, 1 rising, 2 falling, 3 both. Control bit 6 disables the trigger. A qualifying edge acts as a start, taking effect at the third clock edge after the pin changes.
- R8: Control bit 0 enables pulse mode. A write to slot B is kept only when pulse mode is on and the held count field is 2 or 3. A write to slot C is kept only when pulse mode is on and the field is 3. Writes to slot A are always kept.
- R9: Compare values and the count field written while running do not affect the current period. They take effect from the next period or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 command, 2-4 compare A-C) |
| wr_data | input | 16 | Write data |
| trig_in | input | 1 | External start trigger pin |
| pulse_out | output | 1 | Pulse output flip-flop |
| irq | output | 1 | One-cycle period interrupt |

## Verification
The assertions check on every cycle that the count and output hold on cycles without a tick, and that an inverting match really flips the output. They also check that a period end clears the count, restores the starting level and raises the interrupt, that the count never exceeds the active period value, that a stopped timer keeps its level, and that a refused compare write leaves the shadow untouched. Only the bench scenarios can show the timing of the whole pattern. These cover the exact tick at which each edge appears, the period produced by each count-field setting, the trigger latency for rising and falling edges, and that a disabled trigger never starts counting. They also show that compare values written in mid-period apply only from the following period.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } trig_edge_e;

  localparam int ADR_CTL  = 0;
  localparam int ADR_CMD  = 1;
  localparam int ADR_CMP0 = 2;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
endpackage

// File: rtl/ppg_edge_det.sv
module ppg_edge_det
  import ppg_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  trig_edge_e sel,
  input  logic       dis,
  output logic       hit
);
  logic [SYNC:0] sh;
  logic          now_lvl, old_lvl, rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC-1:0], pin};
  end

  assign now_lvl = sh[SYNC-1];
  assign old_lvl = sh[SYNC];
  assign rise    = now_lvl & ~old_lvl;
  assign fall    = ~now_lvl & old_lvl;

  always_comb begin
    hit = 1'b0;
    if (!dis) begin
      unique case (sel)
        EDGE_RISE: hit = rise;
        EDGE_FALL: hit = fall;
        EDGE_BOTH: hit = rise | fall;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ppg_cmp_bank.sv
module ppg_cmp_bank #(
  parameter int W  = 16,
  parameter int N  = 3,
  parameter int CW = $clog2(N + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0]          wr_sel,
  input  logic [W-1:0]          wr_data,
  input  logic                  ppg_en,
  input  logic [CW-1:0]         nreg_req,
  input  logic                  load,
  output logic [N-1:0][W-1:0]   shd_val,
  output logic [N-1:0][W-1:0]   act_val,
  output logic [CW-1:0]         act_n,
  output logic [N-1:0]          wr_ok
);
  function automatic logic [CW-1:0] clamp_used(input logic [CW-1:0] f);
    if (f == '0) return CW'(1);
    if (int'(f) > N) return CW'(N);
    return f;
  endfunction

  logic [CW-1:0] used;
  assign used = clamp_used(nreg_req);

  for (genvar g = 0; g < N; g++) begin : g_slot
    if (g == 0) begin : g_first
      assign wr_ok[g] = wr_sel[g];
    end else begin : g_gated
      assign wr_ok[g] = wr_sel[g] & ppg_en & (CW'(g) < used);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_val[g] <= '0;
        act_val[g] <= '0;
      end else begin
        if (wr_ok[g]) shd_val[g] <= wr_data;
        if (load)     act_val[g] <= shd_val[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    act_n <= CW'(1);
    else if (load) act_n <= used;
  end
endmodule

// File: rtl/ppg_core.sv
module ppg_core #(
  parameter int W  = 16,
  parameter int N  = 3,
  parameter int CW = $clog2(N + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                start,
  input  logic                stop,
  input  logic                init_lvl,
  input  logic [N-1:0][W-1:0] act_val,
  input  logic [CW-1:0]       act_n,
  output logic [W-1:0]        cnt,
  output logic                running,
  output logic                pulse_out,
  output logic                irq,
  output logic [W-1:0]        per_val,
  output logic                period_evt,
  output logic                toggle_hit,
  output logic                load
);
  function automatic logic odd_hits(input logic [N-1:0] m);
    return ^m;
  endfunction

  logic [N-1:0] hit_vec;
  logic         step_ok, at_period;

  always_comb begin
    per_val = '0;
    hit_vec = '0;
    for (int i = 0; i < N; i++) begin
      if (act_n == CW'(i + 1)) per_val = act_val[i];
      if (CW'(i + 1) < act_n)  hit_vec[i] = (cnt == act_val[i]);
    end
  end

  assign step_ok    = tick & running & ~start & ~stop;
  assign at_period  = (cnt == per_val);
  assign period_evt = step_ok & at_period;
  assign toggle_hit = step_ok & ~at_period & odd_hits(hit_vec);
  assign load       = start | period_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      running   <= 1'b0;
      pulse_out <= 1'b0;
      irq       <= 1'b0;
    end else begin
      irq <= period_evt;
      if (start) begin
        cnt       <= '0;
        running   <= 1'b1;
        pulse_out <= init_lvl;
      end else if (stop) begin
        running <= 1'b0;
      end else if (period_evt) begin
        cnt       <= '0;
        pulse_out <= init_lvl;
      end else if (step_ok) begin
        cnt <= cnt + 1'b1;
        if (toggle_hit) pulse_out <= ~pulse_out;
      end
    end
  end
endmodule

// File: rtl/ppg_timer.sv
module ppg_timer
  import ppg_pkg::*;
#(
  parameter int W    = 16,
  parameter int N    = 3,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          trig_in,
  output logic          pulse_out,
  output logic          irq
);
  localparam int CW      = $clog2(N + 1);
  localparam int B_NREG  = 1;
  localparam int B_INIT  = B_NREG + CW;
  localparam int B_EDGE  = B_INIT + 1;
  localparam int B_DIS   = B_EDGE + 2;

  logic                ppg_en, init_lvl, trig_dis;
  logic [CW-1:0]       nreg_req;
  trig_edge_e          edge_sel;

  logic                wr_ctl, start_cmd, stop_cmd, trig_hit, start, stop;
  logic [N-1:0]        wr_sel, wr_ok;
  logic [N-1:0][W-1:0] shd_val, act_val;
  logic [CW-1:0]       act_n;
  logic [W-1:0]        cnt, per_val;
  logic                running, period_evt, toggle_hit, load;

  assign wr_ctl    = wr_en && (wr_addr == AW'(ADR_CTL));
  assign start_cmd = wr_en && (wr_addr == AW'(ADR_CMD)) && wr_data[CMD_START_BIT];
  assign stop_cmd  = wr_en && (wr_addr == AW'(ADR_CMD)) && wr_data[CMD_STOP_BIT]
                     && !wr_data[CMD_START_BIT];

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign wr_sel[g] = wr_en && (wr_addr == AW'(ADR_CMP0 + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ppg_en   <= 1'b0;
      nreg_req <= '0;
      init_lvl <= 1'b0;
      edge_sel <= EDGE_OFF;
      trig_dis <= 1'b0;
    end else if (wr_ctl) begin
      ppg_en   <= wr_data[0];
      nreg_req <= wr_data[B_NREG +: CW];
      init_lvl <= wr_data[B_INIT];
      edge_sel <= trig_edge_e'(wr_data[B_EDGE +: 2]);
      trig_dis <= wr_data[B_DIS];
    end
  end

  ppg_edge_det #(.SYNC(SYNC)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (trig_in),
    .sel   (edge_sel),
    .dis   (trig_dis),
    .hit   (trig_hit)
  );

  assign start = start_cmd | trig_hit;
  assign stop  = stop_cmd;

  ppg_cmp_bank #(.W(W), .N(N), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ppg_en   (ppg_en),
    .nreg_req (nreg_req),
    .load     (load),
    .shd_val  (shd_val),
    .act_val  (act_val),
    .act_n    (act_n),
    .wr_ok    (wr_ok)
  );

  ppg_core #(.W(W), .N(N), .CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .start      (start),
    .stop       (stop),
    .init_lvl   (init_lvl),
    .act_val    (act_val),
    .act_n      (act_n),
    .cnt        (cnt),
    .running    (running),
    .pulse_out  (pulse_out),
    .irq        (irq),
    .per_val    (per_val),
    .period_evt (period_evt),
    .toggle_hit (toggle_hit),
    .load       (load)
  );
endmodule

// File: rtl/ppg_timer_chk.sv
module ppg_timer_chk #(
  parameter int W = 16,
  parameter int N = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                tick,
  input logic                start,
  input logic                running,
  input logic                pulse_out,
  input logic                irq,
  input logic                init_lvl,
  input logic [W-1:0]        cnt,
  input logic [W-1:0]        per_val,
  input logic                period_evt,
  input logic                toggle_hit,
  input logic [N-1:0]        wr_sel,
  input logic [N-1:0]        wr_ok,
  input logic [N-1:0][W-1:0] shd_val
);
  a_r2_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !tick && !start) |=> ($stable(cnt) && $stable(pulse_out)));

  a_r3_match_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    toggle_hit |=> (pulse_out != $past(pulse_out)));

  a_r4_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> (cnt == '0 && irq && pulse_out == $past(init_lvl)));

  a_r4_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt == '0 && running));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= per_val));

  a_r6_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !start) |=> ($stable(pulse_out) && !irq));

  for (genvar g = 0; g < N; g++) begin : g_blk
    a_r8_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[g] && !wr_ok[g]) |=> $stable(shd_val[g]));
  end
endmodule

bind ppg_timer ppg_timer_chk #(.W(W), .N(N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .start      (start),
  .running    (running),
  .pulse_out  (pulse_out),
  .irq        (irq),
  .init_lvl   (init_lvl),
  .cnt        (cnt),
  .per_val    (per_val),
  .period_evt (period_evt),
  .toggle_hit (toggle_hit),
  .wr_sel     (wr_sel),
  .wr_ok      (wr_ok),
  .shd_val    (shd_val)
);

// File: tb/test_ppg_timer.sv
module test_ppg_timer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        trig_in = 1'b0;
  logic        pulse_out, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  ppg_timer i_ppg_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig_in   (trig_in),
    .pulse_out (pulse_out),
    .irq       (irq)
  );

  function automatic logic [15:0] ctlw(input logic ppg, input logic [1:0] nreg,
                                       input logic init, input logic [1:0] edg,
                                       input logic dis);
    return {9'd0, dis, edg, init, nreg, ppg};
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_start(); wr(3'd1, 16'd1); endtask
  task automatic do_stop();  wr(3'd1, 16'd2); endtask

  task automatic t_reset();
    chk("R1", "pulse_out after reset", pulse_out, 0);
    chk("R1", "irq after reset", irq, 0);
    begin
      int seen = 0;
      for (int i = 0; i < 10; i++) begin step(1); seen += irq; end
      chk("R1", "no irq while never started", seen, 0);
    end
  endtask

  task automatic t_two_regs();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd0, 0));
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd7);
    do_start();
    chk("R5", "start loads init level", pulse_out, 0);
    step(3); chk("R3", "before A match", pulse_out, 0);
    step(1); chk("R3", "A match inverts", pulse_out, 1);
    step(3); chk("R4", "irq before period", irq, 0);
    chk("R4", "level held before period", pulse_out, 1);
    step(1); chk("R4", "irq at period end", irq, 1);
    chk("R4", "level restored at period", pulse_out, 0);
    step(1); chk("R4", "irq one cycle only", irq, 0);
    step(3); chk("R3", "A match in second period", pulse_out, 1);
    do_stop();
  endtask

  task automatic t_three_low();
    wr(3'd0, ctlw(1, 2'd3, 1, 2'd0, 0));
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd4);
    wr(3'd4, 16'd6);
    do_start();
    step(2); chk("R5", "active-low idle level", pulse_out, 1);
    step(1); chk("R3", "A inverts to low", pulse_out, 0);
    step(2); chk("R3", "B inverts back", pulse_out, 1);
    step(1); chk("R4", "no irq before C", irq, 0);
    step(1); chk("R4", "C ends period", irq, 1);
    chk("R4", "three-slot level restored", pulse_out, 1);
    do_stop();
  endtask

  task automatic t_blocking();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd0, 0));
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd5);
    wr(3'd0, ctlw(1, 2'd1, 0, 2'd0, 0));
    wr(3'd3, 16'd9);
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd0, 0));
    do_start();
    step(5); chk("R8", "B write refused, no early irq", irq, 0);
    step(1); chk("R8", "B kept old value 5", irq, 1);
    do_stop();
    wr(3'd0, ctlw(1, 2'd3, 0, 2'd0, 0));
    wr(3'd4, 16'd6);
    wr(3'd0, ctlw(0, 2'd3, 0, 2'd0, 0));
    wr(3'd4, 16'd20);
    wr(3'd0, ctlw(1, 2'd3, 0, 2'd0, 0));
    do_start();
    step(6); chk("R8", "C write in non-pulse mode refused, no irq yet", irq, 0);
    step(1); chk("R8", "C kept old value 6", irq, 1);
    do_stop();
  endtask

  task automatic t_tick_gate();
    wr(3'd0, ctlw(1, 2'd2, 1, 2'd0, 0));
    wr(3'd2, 16'd2);
    wr(3'd3, 16'd10);
    tick = 1'b0;
    do_start();
    step(5);
    chk("R2", "no tick, level held", pulse_out, 1);
    chk("R2", "no tick, no irq", irq, 0);
    tick = 1'b1;
    step(2); chk("R2", "two ticks, no match yet", pulse_out, 1);
    step(1); chk("R3", "third tick matches A", pulse_out, 0);
    do_stop();
  endtask

  task automatic t_stop();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd0, 0));
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd7);
    do_start();
    step(4);
    do_stop();
    begin
      int irqs = 0, moves = 0;
      for (int i = 0; i < 20; i++) begin
        step(1);
        irqs += irq;
        moves += (pulse_out != 1'b1);
      end
      chk("R6", "irq while stopped", irqs, 0);
      chk("R6", "level changes while stopped", moves, 0);
    end
    do_start();
    chk("R5", "restart reloads init level", pulse_out, 0);
    do_stop();
  endtask

  task automatic t_trigger();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd1, 0));
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd7);
    trig_in = 1'b1;
    step(6); chk("R7", "rising start, before A", pulse_out, 0);
    step(1); chk("R7", "rising start, A match timing", pulse_out, 1);
    do_stop();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd2, 0));
    trig_in = 1'b0;
    step(10); chk("R7", "falling start, before period", irq, 0);
    step(1);  chk("R7", "falling start, period timing", irq, 1);
    do_stop();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd1, 1));
    trig_in = 1'b1;
    begin
      int irqs = 0;
      for (int i = 0; i < 30; i++) begin step(1); irqs += irq; end
      chk("R7", "disabled trigger starts nothing", irqs, 0);
    end
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd0, 0));
  endtask

  task automatic t_shadow();
    wr(3'd0, ctlw(1, 2'd2, 0, 2'd0, 0));
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd7);
    do_start();
    wr(3'd2, 16'd1);
    wr(3'd3, 16'd4);
    step(1); chk("R9", "old A still in use", pulse_out, 0);
    step(1); chk("R9", "old A match", pulse_out, 1);
    step(4); chk("R9", "old period kept", irq, 1);
    step(2); chk("R9", "new A from next period", pulse_out, 1);
    step(2); chk("R9", "no irq before new period", irq, 0);
    step(1); chk("R9", "new period length", irq, 1);
    do_stop();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_two_regs();
    t_three_low();
    t_blocking();
    t_tick_gate();
    t_stop();
    t_trigger();
    t_shadow();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule